// File: doc/BRIEF.md
# Segmentation Ring Descriptor Fetcher

This block decides, for one transmit channel at a time, whether a cell opportunity may go ahead. A cell opportunity comes in with a snapshot of the channel's state: an active flag, a ring base offset, a ring index and the current buffer address. If the channel is already active, a packet is in progress. The opportunity goes ahead at once and the state comes back unchanged.

If the channel is idle, the block fetches one ring entry. The entry address is the base offset plus four times the index. The block reads that 32-bit entry over a request/response memory port and looks at its top bit, which marks ownership. A device-owned entry starts a new packet: the lower 31 bits become the buffer address, the channel is marked active and the index advances. The index wraps to zero at the configured ring length. A host-owned entry makes the block skip this opportunity and leave the state as it was, rather than wait.

The opportunity input and both memory channels are valid/ready streams. A transfer happens on a rising edge where valid and ready are both high. An initiator holds valid and its payload steady until that edge. The block accepts a new opportunity only in its idle state, so `opp_ready` acts as back-pressure for the whole fetch. The block holds `rd_req_valid` and the address until `rd_req_ready`. It raises `rd_rsp_ready` only while it waits for its single outstanding read. `ring_len` is a plain control input and must stay stable while a fetch is in flight.

Top module: `seg_ring_fetch`

## Requirements
- R1: While reset is asserted and just after it, `opp_ready` is 1 and `done`, `rd_req_valid` and `rd_rsp_ready` are 0.
- R2: An opportunity is taken on an edge with `opp_valid` and `opp_ready` both high. From that edge until the done pulse has ended, `opp_ready` stays 0 and the block ignores changes on the `opp_*` inputs.
- R3: An opportunity with `opp_active`=1 issues no read. It raises `done` in the cycle after acceptance, with `proceed`=1 and `started`=0, and the outputs `out_active`, `out_idx` and `out_buf` equal the accepted inputs.
- R4: An opportunity with `opp_active`=0 raises `rd_req_valid` in the cycle after acceptance. `rd_req_addr` equals `opp_base` + 4×`opp_idx` (modulo 2^ADDR_W). Both are held until the edge where `rd_req_ready` is high.
- R5: Only one read is outstanding. After the request handshake, `rd_req_valid` stays 0 and `rd_rsp_ready` stays 1 until the response edge. `done` stays 0 during that wait.
- R6: A response with bit 31 = 1 (device-owned) gives `proceed`=1, `started`=1, `out_active`=1, and `out_buf` equal to bits 30:0 of the entry, zero-extended. `out_idx` is `opp_idx`+1 when that value is below `ring_len`.
- R7: When `opp_idx`+1 is greater than or equal to `ring_len` (an unsigned value of IDX_W+1 bits), a device-owned start sets `out_idx` to 0.
- R8: A response with bit 31 = 0 (host-owned) gives `proceed`=0, `started`=0, `out_active`=0, and `out_idx` and `out_buf` equal to the accepted inputs.
- R9: `done` is high for exactly one cycle, the cycle after the response handshake edge (or after acceptance, in the case of R3). `opp_ready` returns to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ring_len | input | IDX_W+1 | Number of ring entries; the index wraps at this value |
| opp_valid | input | 1 | Cell opportunity offered |
| opp_ready | output | 1 | Block is idle and takes the opportunity |
| opp_active | input | 1 | Channel active flag |
| opp_base | input | ADDR_W | Channel ring base offset (byte address) |
| opp_idx | input | IDX_W | Channel ring index |
| opp_buf | input | ADDR_W | Channel current buffer address |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory takes the request |
| rd_req_addr | output | ADDR_W | Byte address of the ring entry |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Block waits for read data |
| rd_rsp_data | input | DATA_W | Ring entry: bit 31 ownership (1 = device), bits 30:0 pointer |
| done | output | 1 | One-cycle result pulse |
| proceed | output | 1 | Opportunity goes ahead (valid with done) |
| started | output | 1 | A new packet was started (valid with done) |
| out_active | output | 1 | Updated active flag |
| out_idx | output | IDX_W | Updated ring index |
| out_buf | output | ADDR_W | Updated buffer address |

## Verification
Each result has a fixed due cycle:
- The read request appears one cycle after acceptance.
- The done pulse follows one cycle after the response handshake edge, or one cycle after acceptance for an active channel.
- `opp_ready` returns one cycle after that.

The bench drives all inputs on falling edges and samples at the falling edge that follows each of these rising edges. It checks the request address on every cycle that the memory model holds it off, and checks that `done` stays low through every response delay. The memory model's latencies vary from 0 to 3 cycles, so each due cycle is exercised under several timings.

// File: rtl/srf_pkg.sv
package srf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } srf_state_e;
endpackage

// File: rtl/srf_addr_gen.sv
module srf_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 8,
  parameter int STRIDE_LG2 = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] offs;
  assign offs = ADDR_W'(idx) << STRIDE_LG2;
  assign addr = base + offs;
endmodule

// File: rtl/srf_entry_eval.sv
module srf_entry_eval #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] entry,
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic [IDX_W:0]    ring_len,
  output logic              owned,
  output logic [IDX_W-1:0]  nxt_idx,
  output logic [ADDR_W-1:0] nxt_buf
);
  localparam int PTR_W = DATA_W - 1;

  logic [IDX_W:0] inc;

  assign owned = entry[DATA_W-1];
  assign inc   = {1'b0, cur_idx} + 1'b1;

  always_comb begin
    if (inc >= ring_len) nxt_idx = '0;
    else                 nxt_idx = inc[IDX_W-1:0];
  end

  generate
    if (ADDR_W >= PTR_W) begin : g_ext
      assign nxt_buf = ADDR_W'(entry[PTR_W-1:0]);
    end else begin : g_trunc
      assign nxt_buf = entry[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/srf_ctrl.sv
module srf_ctrl
  import srf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opp_valid,
  output logic              opp_ready,
  input  logic              opp_active,
  input  logic [ADDR_W-1:0] opp_base,
  input  logic [IDX_W-1:0]  opp_idx,
  input  logic [ADDR_W-1:0] opp_buf,
  output logic [ADDR_W-1:0] cap_base,
  output logic [IDX_W-1:0]  cap_idx,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic              owned,
  input  logic [IDX_W-1:0]  nxt_idx,
  input  logic [ADDR_W-1:0] nxt_buf,
  output logic              done,
  output logic              proceed,
  output logic              started,
  output logic              out_active,
  output logic [IDX_W-1:0]  out_idx,
  output logic [ADDR_W-1:0] out_buf
);
  srf_state_e        state;
  logic [ADDR_W-1:0] cap_buf;

  assign opp_ready    = (state == ST_IDLE);
  assign rd_req_valid = (state == ST_REQ);
  assign rd_rsp_ready = (state == ST_WAIT);
  assign done         = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cap_base   <= '0;
      cap_idx    <= '0;
      cap_buf    <= '0;
      proceed    <= 1'b0;
      started    <= 1'b0;
      out_active <= 1'b0;
      out_idx    <= '0;
      out_buf    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (opp_valid) begin
          cap_base <= opp_base;
          cap_idx  <= opp_idx;
          cap_buf  <= opp_buf;
          if (opp_active) begin
            out_active <= 1'b1;
            out_idx    <= opp_idx;
            out_buf    <= opp_buf;
            proceed    <= 1'b1;
            started    <= 1'b0;
            state      <= ST_DONE;
          end else begin
            state <= ST_REQ;
          end
        end
        ST_REQ: if (rd_req_ready) state <= ST_WAIT;
        ST_WAIT: if (rd_rsp_valid) begin
          if (owned) begin
            out_active <= 1'b1;
            out_idx    <= nxt_idx;
            out_buf    <= nxt_buf;
            proceed    <= 1'b1;
            started    <= 1'b1;
          end else begin
            out_active <= 1'b0;
            out_idx    <= cap_idx;
            out_buf    <= cap_buf;
            proceed    <= 1'b0;
            started    <= 1'b0;
          end
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  accept_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opp_valid && opp_ready) |=> !opp_ready)
    else $error("opportunity taken while busy");

  // R3
  active_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opp_valid && opp_ready && opp_active) |=> (done && !rd_req_valid && proceed))
    else $error("active channel did not pass through");

  // R5
  single_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_ready && !rd_rsp_valid) |=> (!rd_req_valid && !done))
    else $error("second request while one outstanding");

  // R6
  start_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && started) |-> (proceed && out_active))
    else $error("start result inconsistent");

  // R8
  skip_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !proceed) |-> (!started && !out_active))
    else $error("skip result inconsistent");

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && opp_ready))
    else $error("done longer than one cycle");
endmodule

// File: rtl/seg_ring_fetch.sv
module seg_ring_fetch #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W:0]    ring_len,
  input  logic              opp_valid,
  output logic              opp_ready,
  input  logic              opp_active,
  input  logic [ADDR_W-1:0] opp_base,
  input  logic [IDX_W-1:0]  opp_idx,
  input  logic [ADDR_W-1:0] opp_buf,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              done,
  output logic              proceed,
  output logic              started,
  output logic              out_active,
  output logic [IDX_W-1:0]  out_idx,
  output logic [ADDR_W-1:0] out_buf
);
  localparam int STRIDE_LG2 = $clog2(DATA_W / 8);

  logic [ADDR_W-1:0] cap_base;
  logic [IDX_W-1:0]  cap_idx;
  logic              owned;
  logic [IDX_W-1:0]  nxt_idx;
  logic [ADDR_W-1:0] nxt_buf;

  srf_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .STRIDE_LG2(STRIDE_LG2)) u_addr (
    .base (cap_base),
    .idx  (cap_idx),
    .addr (rd_req_addr)
  );

  srf_entry_eval #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_eval (
    .entry    (rd_rsp_data),
    .cur_idx  (cap_idx),
    .ring_len (ring_len),
    .owned    (owned),
    .nxt_idx  (nxt_idx),
    .nxt_buf  (nxt_buf)
  );

  srf_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .opp_valid    (opp_valid),
    .opp_ready    (opp_ready),
    .opp_active   (opp_active),
    .opp_base     (opp_base),
    .opp_idx      (opp_idx),
    .opp_buf      (opp_buf),
    .cap_base     (cap_base),
    .cap_idx      (cap_idx),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_ready (rd_rsp_ready),
    .owned        (owned),
    .nxt_idx      (nxt_idx),
    .nxt_buf      (nxt_buf),
    .done         (done),
    .proceed      (proceed),
    .started      (started),
    .out_active   (out_active),
    .out_idx      (out_idx),
    .out_buf      (out_buf)
  );

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)))
    else $error("request dropped or address moved");
endmodule

// File: tb/seg_ring_fetch_test.sv
module seg_ring_fetch_test;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 8;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic [IDX_W:0]    ring_len;
  logic              opp_valid, opp_ready, opp_active;
  logic [ADDR_W-1:0] opp_base, opp_buf;
  logic [IDX_W-1:0]  opp_idx;
  logic              rd_req_valid, rd_req_ready;
  logic [ADDR_W-1:0] rd_req_addr;
  logic              rd_rsp_valid, rd_rsp_ready;
  logic [DATA_W-1:0] rd_rsp_data;
  logic              done, proceed, started, out_active;
  logic [IDX_W-1:0]  out_idx;
  logic [ADDR_W-1:0] out_buf;

  seg_ring_fetch #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .ring_len(ring_len),
    .opp_valid(opp_valid), .opp_ready(opp_ready), .opp_active(opp_active),
    .opp_base(opp_base), .opp_idx(opp_idx), .opp_buf(opp_buf),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .done(done), .proceed(proceed), .started(started),
    .out_active(out_active), .out_idx(out_idx), .out_buf(out_buf)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [IDX_W-1:0] exp_next(input logic [IDX_W-1:0] i,
                                                 input logic [IDX_W:0] len);
    int n;
    n = int'(i) + 1;
    if (n >= int'(len)) return '0;
    return IDX_W'(n);
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [IDX_W-1:0] i);
    return b + (ADDR_W'(i) * 4);
  endfunction

  task automatic run_txn(input bit act, input logic [ADDR_W-1:0] base,
                         input logic [IDX_W-1:0] idx, input logic [ADDR_W-1:0] bufa,
                         input logic [IDX_W:0] len, input logic [DATA_W-1:0] entry,
                         input int req_lat, input int rsp_lat);
    logic [IDX_W-1:0]  e_idx;
    logic [ADDR_W-1:0] e_addr;
    bit                wrap;
    @(negedge clk);
    ring_len   = len;
    opp_active = act;
    opp_base   = base;
    opp_idx    = idx;
    opp_buf    = bufa;
    opp_valid  = 1'b1;
    chk(opp_ready === 1'b1, "R2", "ready before accept", longint'(opp_ready), 1);
    @(negedge clk);
    opp_valid  = 1'b0;
    opp_active = ~act;
    opp_base   = $urandom;
    opp_idx    = IDX_W'($urandom);
    opp_buf    = $urandom;
    chk(opp_ready === 1'b0, "R2", "ready while busy", longint'(opp_ready), 0);
    if (act) begin
      chk(done === 1'b1, "R3", "done", longint'(done), 1);
      chk(rd_req_valid === 1'b0, "R3", "no read", longint'(rd_req_valid), 0);
      chk(proceed === 1'b1 && started === 1'b0, "R3", "proceed/started",
          longint'({proceed, started}), 2);
      chk(out_active === 1'b1 && out_idx === idx && out_buf === bufa, "R3", "state passthrough",
          longint'(out_buf), longint'(bufa));
    end else begin
      e_addr = exp_addr(base, idx);
      for (int k = 0; k <= req_lat; k++) begin
        chk(rd_req_valid === 1'b1, "R4", "request valid", longint'(rd_req_valid), 1);
        chk(rd_req_addr === e_addr, "R4", "request address", longint'(rd_req_addr), longint'(e_addr));
        if (k == req_lat) rd_req_ready = 1'b1;
        @(negedge clk);
      end
      rd_req_ready = 1'b0;
      for (int k = 0; k < rsp_lat; k++) begin
        chk(rd_req_valid === 1'b0 && rd_rsp_ready === 1'b1, "R5", "single outstanding",
            longint'({rd_req_valid, rd_rsp_ready}), 1);
        chk(done === 1'b0, "R5", "done during wait", longint'(done), 0);
        @(negedge clk);
      end
      chk(rd_rsp_ready === 1'b1, "R5", "response ready", longint'(rd_rsp_ready), 1);
      rd_rsp_valid = 1'b1;
      rd_rsp_data  = entry;
      @(negedge clk);
      rd_rsp_valid = 1'b0;
      rd_rsp_data  = $urandom;
      chk(done === 1'b1, "R9", "done after response", longint'(done), 1);
      if (entry[DATA_W-1]) begin
        e_idx = exp_next(idx, len);
        wrap  = (int'(idx) + 1 >= int'(len));
        chk(proceed === 1'b1 && started === 1'b1 && out_active === 1'b1, "R6", "start flags",
            longint'({proceed, started, out_active}), 7);
        chk(out_buf === ADDR_W'(entry[DATA_W-2:0]), "R6", "buffer pointer",
            longint'(out_buf), longint'(entry[DATA_W-2:0]));
        if (wrap) chk(out_idx === e_idx, "R7", "index wrap", longint'(out_idx), longint'(e_idx));
        else      chk(out_idx === e_idx, "R6", "index advance", longint'(out_idx), longint'(e_idx));
      end else begin
        chk(proceed === 1'b0 && started === 1'b0 && out_active === 1'b0, "R8", "skip flags",
            longint'({proceed, started, out_active}), 0);
        chk(out_idx === idx && out_buf === bufa, "R8", "state unchanged",
            longint'(out_buf), longint'(bufa));
      end
    end
    @(negedge clk);
    chk(done === 1'b0, "R9", "pulse width", longint'(done), 0);
    chk(opp_ready === 1'b1, "R9", "ready returns", longint'(opp_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [IDX_W:0] len;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    ring_len = 9'd16;
    opp_valid = 1'b0; opp_active = 1'b0; opp_base = '0; opp_idx = '0; opp_buf = '0;
    rd_req_ready = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    repeat (3) @(negedge clk);
    chk(opp_ready === 1'b1 && done === 1'b0, "R1", "reset ready/done",
        longint'({opp_ready, done}), 2);
    chk(rd_req_valid === 1'b0 && rd_rsp_ready === 1'b0, "R1", "reset memory port",
        longint'({rd_req_valid, rd_rsp_ready}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(opp_ready === 1'b1 && done === 1'b0, "R1", "after reset",
        longint'({opp_ready, done}), 2);

    // directed corners
    run_txn(1'b1, 32'h0000_1000, 8'd3, 32'hABCD_0040, 9'd16, 32'h0, 0, 0);          // R3
    run_txn(1'b0, 32'h0000_2000, 8'd5, 32'h1111_2222, 9'd16, 32'h7FFF_FFF0, 0, 0);   // R8
    run_txn(1'b0, 32'h0000_2000, 8'd5, 32'h1111_2222, 9'd16, 32'h8000_0400, 3, 2);   // R6 R4
    run_txn(1'b0, 32'h0000_3000, 8'd15, 32'h0, 9'd16, 32'hC000_0010, 1, 0);          // R7
    run_txn(1'b0, 32'hFFFF_FFF0, 8'd255, 32'h0, 9'd256, 32'hFFFF_FFFF, 0, 3);        // R7 R4 wrap
    run_txn(1'b0, 32'h0000_4000, 8'd0, 32'h0, 9'd1, 32'h8000_0000, 2, 1);            // R7 size 1

    // constrained random
    for (int t = 0; t < 80; t++) begin
      len = IDX_W'($urandom_range(0, 255)) + 9'd1;
      run_txn(($urandom_range(0, 3) == 0), $urandom, IDX_W'($urandom % int'(len)), $urandom,
              len, $urandom, $urandom_range(0, 3), $urandom_range(0, 3));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule